// File: doc/BRIEF.md
# Byte-wide register-memory CPU core

A compact multi-cycle processor core. It fetches 32-bit instruction words from a synchronous, word-addressed memory and executes three arithmetic families: move, add and subtract. It also executes five jumps that test the flags. Values are 8-bit bytes that sit in the most significant byte of a word. Each operation has its own opcode for each pairing of destination and source: register/register, memory/register, register/memory, memory/constant and register/constant. No form moves memory to memory.

A host loads memory while the core is stopped, then pulses `start_i`. The core clears its registers and flags and fetches from word `START_WORD`. It runs until it fetches an all-zero opcode byte, or until it meets an opcode or register code it does not recognise. The host then reads results from memory, or from the debug outputs that expose the four general registers and the flags.

Top module: `byte_cpu_core`

## Requirements
- R1: After reset, `halted_o`=1, `error_o`=0, all registers and flags are zero, and `mem_we_o`=0. While `start_i` is low the core stays stopped and does not write memory.
- R2: A `start_i` pulse clears the registers, flags and error, then begins fetching at word `START_WORD` (default 8). The instruction word holds the opcode in bits 31:24, operand 1 in bits 23:16 and operand 2 in bits 15:8; bits 7:0 are ignored.
- R3: Fetching opcode 0x00 stops the core with `error_o`=0. It stays stopped with its state held until the next start.
- R4: MOVE uses opcodes 0x81 (reg←reg), 0x82 (mem←reg), 0x83 (reg←mem), 0x84 (mem←const) and 0x85 (reg←const). Operand 1 is the destination and operand 2 the source. Register codes 1 to 4 select A to D. MOVE leaves the flags unchanged.
- R5: ADD uses opcodes 0x86 to 0x8A, with the same five forms in the same order. The 8-bit sum wraps.
- R6: SUB uses opcodes 0x8B to 0x8F, with the same five forms. It computes destination minus source and wraps to 8 bits.
- R7: ADD and SUB set the flags from the 8-bit result. `dbg_flags_o` bit 0 is positive (nonzero, msb clear), bit 1 is negative (msb set), bit 2 is zero, and bit 3 is two's-complement overflow.
- R8: A memory destination is written as {result, 24'h0} to the word named by operand 1, with `mem_we_o` high for exactly one cycle. Memory operands read the byte in bits 31:24 of the word they name.
- R9: Opcode 0x90 always jumps. Opcodes 0x91, 0x92, 0x93 and 0x94 jump when the flag positive, negative, zero or overflow is set. The target is the absolute word given by operand 1. A jump not taken continues at the next word.
- R10: A nonzero opcode outside 0x81 to 0x94, or a register operand outside 1 to 4, stops the core with `error_o`=1 and without executing the instruction.
- R11: A loop at word 8 that sums 1 to 10 into word 1, with its limit of 11 in word 0, leaves 0x37 in word 1 when the core stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear state and start at START_WORD |
| mem_addr_o | output | AW | Word address to memory |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the address |
| mem_wdata_o | output | 32 | Write data |
| mem_we_o | output | 1 | Write enable |
| halted_o | output | 1 | Core is stopped |
| error_o | output | 1 | Stopped on an unrecognised instruction |
| dbg_regs_o | output | 4*8 | Registers A (7:0), B (15:8), C (23:16), D (31:24) |
| dbg_flags_o | output | 4 | {overflow, zero, negative, positive} |

## Verification
A wrong decode shows in the register or memory contents once the program stops. Each program is short, so the fault appears within a few dozen cycles. A wrong flag does not show until a later conditional jump takes the wrong path, or until the flags are read at the stop. The jump programs therefore place a marker move in every path a wrong branch would take. The state machine is checked at each edge: the stop state must hold, write enable must be a single-cycle pulse, and an error must never appear while the core is running.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;
  localparam int DW = 8;
  localparam int WW = 32;

  localparam logic [7:0] OPC_ALU_LO  = 8'h81;
  localparam logic [7:0] OPC_ALU_HI  = 8'h8F;
  localparam logic [7:0] OPC_JMP_LO  = 8'h90;
  localparam logic [7:0] OPC_JMP_HI  = 8'h94;
  localparam logic [7:0] FORMS       = 8'd5;

  typedef enum logic [1:0] {OP_MOV, OP_ADD, OP_SUB} alu_op_e;
  typedef enum logic [2:0] {AM_RR, AM_MR, AM_RM, AM_MC, AM_RC} amode_e;
  typedef enum logic [1:0] {IC_HALT, IC_ALU, IC_JUMP, IC_BAD} iclass_e;
  typedef enum logic [1:0] {S_STOP, S_FETCH, S_DECODE, S_MEM} state_e;

  typedef struct packed {
    iclass_e    cls;
    alu_op_e    op;
    amode_e     mode;
    logic [2:0] cond;
    logic       need_mem;
    logic       mem_dst;
  } dec_t;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic neg;
    logic pos;
  } flags_t;
endpackage

// File: rtl/byte_cpu_decode.sv
module byte_cpu_decode
  import byte_cpu_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic [7:0] opcode_i,
  input  logic [7:0] opnd1_i,
  input  logic [7:0] opnd2_i,
  output dec_t       dec_o
);
  logic [7:0] idx;
  logic       r1_ok, r2_ok, need_r1, need_r2;

  assign idx   = opcode_i - OPC_ALU_LO;
  assign r1_ok = (opnd1_i != 8'd0) && (opnd1_i <= 8'(NREGS));
  assign r2_ok = (opnd2_i != 8'd0) && (opnd2_i <= 8'(NREGS));

  always_comb begin
    dec_o          = '0;
    dec_o.cls      = IC_BAD;
    dec_o.op       = OP_MOV;
    dec_o.mode     = AM_RR;
    need_r1        = 1'b0;
    need_r2        = 1'b0;
    if (opcode_i == 8'h00) begin
      dec_o.cls = IC_HALT;
    end else if (opcode_i >= OPC_ALU_LO && opcode_i <= OPC_ALU_HI) begin
      dec_o.cls = IC_ALU;
      if (idx < FORMS) begin
        dec_o.op   = OP_MOV;
        dec_o.mode = amode_e'(idx[2:0]);
      end else if (idx < 2 * FORMS) begin
        dec_o.op   = OP_ADD;
        dec_o.mode = amode_e'(3'(idx - FORMS));
      end else begin
        dec_o.op   = OP_SUB;
        dec_o.mode = amode_e'(3'(idx - 2 * FORMS));
      end
      need_r1 = dec_o.mode inside {AM_RR, AM_RM, AM_RC};
      need_r2 = dec_o.mode inside {AM_RR, AM_MR};
      dec_o.need_mem = dec_o.mode inside {AM_MR, AM_RM, AM_MC};
      dec_o.mem_dst  = dec_o.mode inside {AM_MR, AM_MC};
      if ((need_r1 && !r1_ok) || (need_r2 && !r2_ok)) begin
        dec_o.cls      = IC_BAD;
        dec_o.need_mem = 1'b0;
        dec_o.mem_dst  = 1'b0;
      end
    end else if (opcode_i >= OPC_JMP_LO && opcode_i <= OPC_JMP_HI) begin
      dec_o.cls  = IC_JUMP;
      dec_o.cond = 3'(opcode_i - OPC_JMP_LO);
    end
  end
endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
  import byte_cpu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  flags_t        flags_i,
  output logic [DW-1:0] res_o,
  output flags_t        flags_o
);
  logic sa, sb, sr;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      default: res_o = b_i;
    endcase
  end

  assign sa = a_i[DW-1];
  assign sb = b_i[DW-1];
  assign sr = res_o[DW-1];

  always_comb begin
    flags_o = flags_i;
    if (op_i != OP_MOV) begin
      flags_o.zero = (res_o == '0);
      flags_o.neg  = sr;
      flags_o.pos  = !sr && (res_o != '0);
      flags_o.ovf  = (op_i == OP_ADD) ? (sa == sb) && (sr != sa)
                                      : (sa != sb) && (sr != sa);
    end
  end
endmodule

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile
  import byte_cpu_pkg::*;
#(
  parameter int NREGS = 4,
  localparam int RW = $clog2(NREGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  logic [RW-1:0]       widx_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [RW-1:0]       ridx1_i,
  input  logic [RW-1:0]       ridx2_i,
  output logic [DW-1:0]       rdata1_o,
  output logic [DW-1:0]       rdata2_o,
  output logic [NREGS*DW-1:0] flat_o
);
  logic [DW-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= '0;
      else if (clr_i)                           regs_q[g] <= '0;
      else if (we_i && widx_i == RW'(g))        regs_q[g] <= wdata_i;
    end
    assign flat_o[g*DW +: DW] = regs_q[g];
  end

  assign rdata1_o = regs_q[ridx1_i];
  assign rdata2_o = regs_q[ridx2_i];
endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core
  import byte_cpu_pkg::*;
#(
  parameter int AW         = 8,
  parameter int NREGS      = 4,
  parameter int START_WORD = 8,
  localparam int RW = $clog2(NREGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic [AW-1:0]       mem_addr_o,
  input  logic [WW-1:0]       mem_rdata_i,
  output logic [WW-1:0]       mem_wdata_o,
  output logic                mem_we_o,
  output logic                halted_o,
  output logic                error_o,
  output logic [NREGS*DW-1:0] dbg_regs_o,
  output logic [3:0]          dbg_flags_o
);
  state_e        state_q;
  logic [AW-1:0] pc_q;
  logic [23:0]   ir_q;
  flags_t        flags_q, flags_nx;
  logic          err_q;

  logic [23:0]   inst;
  logic [7:0]    opc, opnd1, opnd2;
  dec_t          dec;
  logic [DW-1:0] rd1, rd2, mem_byte, a_val, b_val, res;
  logic          commit, reg_we, taken;
  logic [AW-1:0] opnd_addr;
  logic          unused_lo;

  assign unused_lo = ^mem_rdata_i[7:0];

  // decode from live read data in S_DECODE, from the latched word afterwards
  assign inst  = (state_q == S_DECODE) ? mem_rdata_i[31:8] : ir_q;
  assign opc   = inst[23:16];
  assign opnd1 = inst[15:8];
  assign opnd2 = inst[7:0];

  byte_cpu_decode #(.NREGS(NREGS)) u_dec (
    .opcode_i (opc),
    .opnd1_i  (opnd1),
    .opnd2_i  (opnd2),
    .dec_o    (dec)
  );

  assign mem_byte = mem_rdata_i[WW-1 -: DW];

  always_comb begin
    unique case (dec.mode)
      AM_RR, AM_MR: b_val = rd2;
      AM_RM:        b_val = mem_byte;
      default:      b_val = opnd2;
    endcase
    a_val = dec.mem_dst ? mem_byte : rd1;
  end

  byte_cpu_alu u_alu (
    .op_i    (dec.op),
    .a_i     (a_val),
    .b_i     (b_val),
    .flags_i (flags_q),
    .res_o   (res),
    .flags_o (flags_nx)
  );

  assign commit = ((state_q == S_DECODE) && dec.cls == IC_ALU && !dec.need_mem) ||
                  (state_q == S_MEM);
  assign reg_we = commit && !dec.mem_dst;

  byte_cpu_regfile #(.NREGS(NREGS)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .we_i     (reg_we && !start_i),
    .widx_i   (RW'(opnd1 - 8'd1)),
    .wdata_i  (res),
    .ridx1_i  (RW'(opnd1 - 8'd1)),
    .ridx2_i  (RW'(opnd2 - 8'd1)),
    .rdata1_o (rd1),
    .rdata2_o (rd2),
    .flat_o   (dbg_regs_o)
  );

  always_comb begin
    unique case (dec.cond)
      3'd0:    taken = 1'b1;
      3'd1:    taken = flags_q.pos;
      3'd2:    taken = flags_q.neg;
      3'd3:    taken = flags_q.zero;
      3'd4:    taken = flags_q.ovf;
      default: taken = 1'b0;
    endcase
  end

  assign opnd_addr   = AW'((dec.mode == AM_RM) ? opnd2 : opnd1);
  assign mem_addr_o  = (state_q == S_FETCH) ? pc_q : opnd_addr;
  assign mem_we_o    = (state_q == S_MEM) && dec.mem_dst;
  assign mem_wdata_o = {res, {(WW-DW){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_STOP;
      pc_q    <= AW'(START_WORD);
      ir_q    <= '0;
      flags_q <= '0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= S_FETCH;
      pc_q    <= AW'(START_WORD);
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (commit) flags_q <= flags_nx;
      unique case (state_q)
        S_FETCH: state_q <= S_DECODE;
        S_DECODE: begin
          ir_q <= mem_rdata_i[31:8];
          pc_q <= pc_q + AW'(1);
          unique case (dec.cls)
            IC_HALT: state_q <= S_STOP;
            IC_BAD: begin
              state_q <= S_STOP;
              err_q   <= 1'b1;
            end
            IC_JUMP: begin
              if (taken) pc_q <= AW'(opnd1);
              state_q <= S_FETCH;
            end
            default: state_q <= dec.need_mem ? S_MEM : S_FETCH;
          endcase
        end
        S_MEM:   state_q <= S_FETCH;
        default: state_q <= S_STOP;
      endcase
    end
  end

  assign halted_o    = (state_q == S_STOP);
  assign error_o     = err_q;
  assign dbg_flags_o = flags_q;
endmodule

// File: rtl/byte_cpu_core_chk.sv
module byte_cpu_core_chk #(
  parameter int AW = 8,
  parameter int NREGS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [31:0]         mem_wdata_o,
  input logic                mem_we_o,
  input logic                halted_o,
  input logic                error_o,
  input logic [NREGS*8-1:0]  dbg_regs_o,
  input logic [3:0]          dbg_flags_o
);
  p_stop_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !start_i |=> halted_o && $stable(dbg_regs_o) && $stable(dbg_flags_o));

  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !halted_o && !error_o && dbg_regs_o == '0 && dbg_flags_o == '0);

  p_no_write_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);

  p_err_stopped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> halted_o);

  p_write_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_write_pad_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[23:0] == 24'h0);

  p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dbg_flags_o[2:0]));
endmodule

bind byte_cpu_core byte_cpu_core_chk #(.AW(AW), .NREGS(NREGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .halted_o    (halted_o),
  .error_o     (error_o),
  .dbg_regs_o  (dbg_regs_o),
  .dbg_flags_o (dbg_flags_o)
);

// File: tb/byte_cpu_core_tb.sv
`timescale 1ns/1ps
module byte_cpu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata, mem_wdata;
  logic        mem_we, halted, error;
  logic [31:0] regs;
  logic [3:0]  flags;

  logic [31:0] mem [256];
  logic        clr = 1'b0, ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  byte_cpu_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .halted_o(halted), .error_o(error),
    .dbg_regs_o(regs), .dbg_flags_o(flags)
  );

  always_ff @(posedge clk) begin
    if (clr) for (int i = 0; i < 256; i++) mem[i] <= '0;
    else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [31:0] ins(logic [7:0] o, logic [7:0] a, logic [7:0] b);
    return {o, a, b, 8'h00};
  endfunction
  function automatic logic [31:0] dat(logic [7:0] v);
    return {v, 24'h0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wipe();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask
  task automatic put(int a, logic [31:0] d);
    ld_en = 1'b1; ld_addr = a[7:0]; ld_data = d; @(negedge clk); ld_en = 1'b0;
  endtask
  task automatic run();
    int n = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!halted && n < 5000) begin @(negedge clk); n++; end
    chk("R3 stop reached", {31'b0, halted}, 32'h1);
  endtask

  // sub, a, b, result, flags{ovf,zero,neg,pos}
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 8'h05, 8'h03, 8'h08, 8'h01},
    {8'h00, 8'h7F, 8'h01, 8'h80, 8'h0A},
    {8'h00, 8'hFF, 8'h01, 8'h00, 8'h04},
    {8'h00, 8'h80, 8'h80, 8'h00, 8'h0C},
    {8'h01, 8'h03, 8'h05, 8'hFE, 8'h02},
    {8'h01, 8'h05, 8'h05, 8'h00, 8'h04},
    {8'h01, 8'h80, 8'h01, 8'h7F, 8'h09},
    {8'h01, 8'h7F, 8'hFF, 8'h80, 8'h0A}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 halted", {31'b0, halted}, 32'h1);
    chk("R1 error", {31'b0, error}, 32'h0);
    chk("R1 regs", regs, 32'h0);
    chk("R1 flags", {28'b0, flags}, 32'h0);
    chk("R1 we", {31'b0, mem_we}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle", {31'b0, halted}, 32'h1);

    // R5 R6 R7 vector table on register/constant forms
    foreach (VEC[i]) begin
      wipe();
      put(8,  ins(8'h85, 8'h01, VEC[i][31:24]));
      put(9,  ins(VEC[i][32] ? 8'h8F : 8'h8A, 8'h01, VEC[i][23:16]));
      run();
      chk(VEC[i][32] ? "R6 sub result" : "R5 add result", {24'b0, regs[7:0]}, {24'b0, VEC[i][15:8]});
      chk("R7 flags", {28'b0, flags}, {28'b0, VEC[i][3:0]});
    end

    // R11 sum loop, also R2 start word and R9 jpos
    wipe();
    put(0,  dat(8'h0B));
    put(8,  ins(8'h85, 8'h04, 8'h01));
    put(9,  ins(8'h87, 8'h01, 8'h04));
    put(10, ins(8'h8A, 8'h04, 8'h01));
    put(11, ins(8'h83, 8'h03, 8'h00));
    put(12, ins(8'h8B, 8'h03, 8'h04));
    put(13, ins(8'h91, 8'h09, 8'h00));
    run();
    chk("R11 sum word1", mem[1], 32'h37000000);
    chk("R11 error", {31'b0, error}, 32'h0);
    chk("R2 reg D", {24'b0, regs[31:24]}, 32'h0B);

    // R4 R5 R6 R8 memory forms
    wipe();
    put(0,  dat(8'h10));
    put(8,  ins(8'h84, 8'h02, 8'h22));
    put(9,  ins(8'h83, 8'h02, 8'h02));
    put(10, ins(8'h85, 8'h03, 8'h07));
    put(11, ins(8'h82, 8'h03, 8'h03));
    put(12, ins(8'h8C, 8'h00, 8'h03));
    put(13, ins(8'h89, 8'h03, 8'h05));
    put(14, ins(8'h88, 8'h03, 8'h00));
    put(15, ins(8'h8D, 8'h02, 8'h03));
    put(16, ins(8'h81, 8'h04, 8'h02));
    put(17, ins(8'h86, 8'h01, 8'h04));
    put(18, ins(8'h8B, 8'h01, 8'h03));
    run();
    chk("R4 R5 R6 regs", regs, 32'h16_10_16_06);
    chk("R6 R8 mem0", mem[0], 32'h09000000);
    chk("R4 R8 mem2", mem[2], 32'h22000000);
    chk("R5 R8 mem3", mem[3], 32'h0C000000);
    chk("R7 flags", {28'b0, flags}, 32'h1);

    // R4 move keeps flags; R6 mem/const
    wipe();
    put(8,  ins(8'h8E, 8'h04, 8'h01));
    put(9,  ins(8'h85, 8'h02, 8'h05));
    put(10, ins(8'h84, 8'h05, 8'h00));
    run();
    chk("R6 mem4", mem[4], 32'hFF000000);
    chk("R4 flags kept", {28'b0, flags}, 32'h2);
    chk("R4 reg B", {24'b0, regs[15:8]}, 32'h05);

    // R9 jumps taken and not taken
    wipe();
    put(8,  ins(8'h85, 8'h01, 8'h00));
    put(9,  ins(8'h8A, 8'h01, 8'h00));
    put(10, ins(8'h93, 8'h0C, 8'h00));
    put(11, ins(8'h85, 8'h02, 8'hEE));
    put(12, ins(8'h92, 8'h0E, 8'h00));
    put(13, ins(8'h85, 8'h03, 8'h11));
    put(14, ins(8'h90, 8'h10, 8'h00));
    put(15, ins(8'h85, 8'h04, 8'hEE));
    put(16, ins(8'h94, 8'h12, 8'h00));
    put(17, ins(8'h91, 8'h13, 8'h00));
    put(18, ins(8'h85, 8'h04, 8'h44));
    run();
    chk("R9 jumps", regs, 32'h44_11_00_00);

    wipe();
    put(8,  ins(8'h85, 8'h01, 8'h7F));
    put(9,  ins(8'h8A, 8'h01, 8'h01));
    put(10, ins(8'h94, 8'h0C, 8'h00));
    put(11, ins(8'h85, 8'h02, 8'hEE));
    run();
    chk("R9 jover taken", {24'b0, regs[15:8]}, 32'h0);

    // R10 illegal opcode
    wipe();
    put(8,  ins(8'h85, 8'h01, 8'h05));
    put(9,  ins(8'h95, 8'h02, 8'h03));
    put(10, ins(8'h85, 8'h03, 8'h09));
    run();
    chk("R10 error opcode", {31'b0, error}, 32'h1);
    chk("R10 regs", regs, 32'h00_00_00_05);

    // R10 bad register code, no write
    wipe();
    put(8,  ins(8'h82, 8'h06, 8'h05));
    run();
    chk("R10 error regcode", {31'b0, error}, 32'h1);
    chk("R10 no write", mem[6], 32'h0);

    // R2 R3 restart clears state; stop holds
    wipe();
    put(8, ins(8'h85, 8'h02, 8'h33));
    run();
    wipe();
    run();
    chk("R2 regs cleared", regs, 32'h0);
    chk("R2 error cleared", {31'b0, error}, 32'h0);
    repeat (20) @(negedge clk);
    chk("R3 stop held", {31'b0, halted}, 32'h1);
    chk("R3 mem untouched", mem[8], 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule